// File: doc/BRIEF.md
# Status Flag Register with Paired Set/Clear Commands

This block keeps a small set of controller state flags: a run-mode bit that separates operation from configuration, a master-role bit, a software-only mode fault flag and five error flags for transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Software never rewrites the flags directly. It writes a command word in which every flag owns one set bit and one clear bit, so a flag can be changed without first reading the others.

Each hardware error flag can also be raised by a one-cycle event pulse from the transfer logic, but only when that error's enable bit is on in a small configuration register. The configuration register is locked while the run bit is 1. A level error interrupt is high while any error flag is set. The busy indication of the transfer engine is shown in the status word and prevents leaving run mode in the middle of a transfer.

Top module: `status_setclr_reg`

## Requirements
- R1: After reset the status word is zero apart from the live busy bit, the configuration register reads zero and the error interrupt is low.
- R2: Status word layout: run at bit 0, master at bit 1, mode fault at bit 2, transmit overflow at bit 8, receive overflow at bit 9, abort at bit 10, transmit underflow at bit 11, receive underflow at bit 12, busy at bit 13 (follows the busy input); all other bits read 0.
- R3: Command encoding: bit 0 clears run, bit 1 sets run, bit 2 clears master, bit 3 sets master, bit 4 clears receive underflow, bit 5 sets it, bit 6 clears mode fault, bit 7 sets it; bits 8 to 11 clear transmit overflow, receive overflow, abort and transmit underflow, and bits 12 to 15 set the same four. A command bit at 0 leaves its flag alone; the change shows in the status word in the cycle after the write.
- R4: If a flag's set bit and clear bit are both 1 in one command write, that flag keeps its value.
- R5: The command value 0x0F50 clears all six error flags in one write and leaves run and master unchanged.
- R6: A hardware event sets its error flag only when the matching configuration enable bit is 1; event and enable bits are ordered bit 0 transmit overflow, bit 1 receive overflow, bit 2 abort, bit 3 transmit underflow, bit 4 receive underflow.
- R7: An enabled hardware event in the same cycle as a software clear of that flag leaves the flag set.
- R8: A command that clears run is ignored while busy is 1; it takes effect when busy is 0.
- R9: The error interrupt is high in exactly the cycles in which at least one of the six error flags is set.
- R10: A configuration write takes effect only while run is 0; while run is 1 it is ignored and the configuration readback keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Paired set/clear command bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Per-error hardware enable bits to write |
| err_evt | input | 5 | One-cycle hardware error event pulses |
| busy | input | 1 | Transfer engine busy |
| status_q | output | 16 | Status word |
| cfg_q | output | 5 | Configuration readback |
| err_irq | output | 1 | Error interrupt level |

## Verification
The command path is tried with single set or clear bits, with words that set every flag at once, with the bulk clear value and with words that carry both halves of a pair, which separates a correct pair decode from a design that lets one half win. Hardware events are applied with all enables off, with a mixed enable pattern and together with a software clear, which tells a missing gate or a wrong priority apart from a wrong bit mapping. Leaving run mode is tried with busy high and then low, and configuration writes are tried in both modes, so that both locks are seen to hold and to release.

// File: rtl/status_setclr_pkg.sv
package status_setclr_pkg;

  localparam int NFLAG     = 8;   // run, master, mode fault, five hardware errors
  localparam int NHW       = 5;   // flags with a hardware event input
  localparam int FIRST_ERR = 2;   // flags at and above this index are errors
  localparam int CMD_W     = 16;
  localparam int STAT_W    = 16;
  localparam int BUSY_POS  = 13;

  // flag index: 0 run, 1 master, 2 mode fault, 3 tx ovf, 4 rx ovf,
  //             5 abort, 6 tx unf, 7 rx unf
  function automatic int stat_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 12;
    endcase
  endfunction

  function automatic int clr_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 2;
      2: return 6;
      3: return 8;
      4: return 9;
      5: return 10;
      6: return 11;
      default: return 4;
    endcase
  endfunction

  function automatic int set_pos(input int idx);
    if (idx >= 3 && idx <= 6) return clr_pos(idx) + 4;
    return clr_pos(idx) + 1;
  endfunction

  // index into the event / enable vectors, -1 when software only
  function automatic int hw_pos(input int idx);
    if (idx >= 3) return idx - 3;
    return -1;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/sr_flag_cell.sv
module sr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic hw_set,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (hw_set)                q_d = 1'b1;
    else if (sw_set && !sw_clr) q_d = 1'b1;
    else if (sw_clr && !sw_set) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R4
  pair_conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set && sw_clr && !hw_set) |=> $stable(q));

  // R7
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> q);

  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!q && !sw_set && !hw_set) |=> !q);
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         lock,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         load;

  always_comb begin
    load = wr_en && !lock;
    q_d  = load ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R10
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock) |=> $stable(q));
endmodule

// File: rtl/status_setclr_reg.sv
module status_setclr_reg
  import status_setclr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              cfg_we,
  input  logic [NHW-1:0]    cfg_wdata,
  input  logic [NHW-1:0]    err_evt,
  input  logic              busy,
  output logic [STAT_W-1:0] status_q,
  output logic [NHW-1:0]    cfg_q,
  output logic              err_irq
);
  logic             rst_i_n;
  logic [NFLAG-1:0] flag_q;

  rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cfg_lock_reg #(.W(NHW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr_en (cfg_we),
    .lock  (flag_q[0]),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int SP = set_pos(i);
    localparam int CP = clr_pos(i);
    localparam int HP = hw_pos(i);
    logic sw_set, sw_clr, hw_set;

    assign sw_set = cmd_we && cmd_word[SP];

    if (i == 0) begin : g_run_guard
      // leaving run mode only while the engine is idle
      assign sw_clr = cmd_we && cmd_word[CP] && !busy;
    end else begin : g_plain_clr
      assign sw_clr = cmd_we && cmd_word[CP];
    end

    if (HP >= 0) begin : g_hw
      assign hw_set = err_evt[HP] && cfg_q[HP];
    end else begin : g_no_hw
      assign hw_set = 1'b0;
    end

    sr_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_i_n),
      .sw_set (sw_set),
      .sw_clr (sw_clr),
      .hw_set (hw_set),
      .q      (flag_q[i])
    );
  end

  always_comb begin
    status_q = '0;
    for (int k = 0; k < NFLAG; k++) status_q[stat_pos(k)] = flag_q[k];
    status_q[BUSY_POS] = busy;
    err_irq = |flag_q[NFLAG-1:FIRST_ERR];
  end

  // R8
  run_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_we && cmd_word[clr_pos(0)] && busy && flag_q[0]) |=> status_q[0]);

  // R9
  irq_tracks_errors_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (status_q[12:8] != '0 || status_q[2]) |-> err_irq);

  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(rst_i_n) |-> (cfg_q == '0 && !err_irq));
endmodule

// File: tb/sim_status_setclr_reg.sv
module sim_status_setclr_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [15:0] cmd_word;
  logic        cfg_we;
  logic [4:0]  cfg_wdata;
  logic [4:0]  err_evt;
  logic        busy;
  logic [15:0] status_q;
  logic [4:0]  cfg_q;
  logic        err_irq;

  always #2 clk = ~clk;  // 250 MHz

  status_setclr_reg u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .err_evt(err_evt), .busy(busy),
    .status_q(status_q), .cfg_q(cfg_q), .err_irq(err_irq)
  );

  typedef struct {
    logic [15:0] st;
    logic [4:0]  cfg;
    logic        irq;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference state
  logic m_run, m_ms, m_me;
  logic [4:0] m_err;   // tx ovf, rx ovf, abort, tx unf, rx unf
  logic [4:0] m_cfg;

  function automatic logic upd(input logic cur, input logic s, input logic c, input logic h);
    if (h) return 1'b1;
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic op(input logic we, input logic [15:0] cmd, input logic cwe,
                    input logic [4:0] cd, input logic [4:0] evt, input logic bsy,
                    input string req);
    exp_t e;
    logic [4:0] hw, es, ec;
    @(negedge clk);
    cmd_we = we; cmd_word = cmd; cfg_we = cwe; cfg_wdata = cd;
    err_evt = evt; busy = bsy;
    hw = evt & m_cfg;
    es = we ? {cmd[5], cmd[15:12]} : 5'b0;
    ec = we ? {cmd[4], cmd[11:8]}  : 5'b0;
    if (cwe && !m_run) m_cfg = cd;
    m_run = upd(m_run, we && cmd[1], we && cmd[0] && !bsy, 1'b0);
    m_ms  = upd(m_ms,  we && cmd[3], we && cmd[2], 1'b0);
    m_me  = upd(m_me,  we && cmd[7], we && cmd[6], 1'b0);
    for (int k = 0; k < 5; k++) m_err[k] = upd(m_err[k], es[k], ec[k], hw[k]);
    e.st  = {2'b00, bsy, m_err[4], m_err[3], m_err[2], m_err[1], m_err[0],
             5'b00000, m_me, m_ms, m_run};
    e.cfg = m_cfg;
    e.irq = m_me || (m_err != 5'b0);
    e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: compares just after the edge at which the result appears
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, "status", status_q, e.st);
      check(e.req, "cfg", {11'b0, cfg_q}, {11'b0, e.cfg});
      check(e.req, "irq", {15'b0, err_irq}, {15'b0, e.irq});
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_we = 0; cmd_word = '0; cfg_we = 0; cfg_wdata = '0;
    err_evt = '0; busy = 0;
    m_run = 0; m_ms = 0; m_me = 0; m_err = '0; m_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "status", status_q, 16'h0000);
    check("R1", "cfg", {11'b0, cfg_q}, 16'h0000);
    check("R1", "irq", {15'b0, err_irq}, 16'h0000);

    op(1, 16'h0008, 0, 0, 0, 0, "R3 set master");
    op(1, 16'h0002, 0, 0, 0, 0, "R3 set run");
    op(0, 16'hFFFF, 0, 0, 0, 0, "R3 no strobe");
    op(1, 16'hF0A0, 0, 0, 0, 0, "R2 R9 set all errors");
    op(1, 16'h0F50, 0, 0, 0, 0, "R5 bulk clear");
    op(1, 16'h1000, 0, 0, 0, 0, "R3 set tx ovf");
    op(1, 16'h33C0, 0, 0, 0, 0, "R4 pair conflict");
    op(1, 16'h000C, 0, 0, 0, 0, "R4 master conflict");
    op(1, 16'h0100, 0, 0, 0, 0, "R3 clear tx ovf");
    op(1, 16'h0080, 0, 0, 0, 0, "R9 mode fault only");
    op(1, 16'h0040, 0, 0, 0, 0, "R9 mode fault clear");
    op(0, 16'h0000, 1, 5'h1F, 0, 0, "R10 cfg write locked");
    op(0, 16'h0000, 0, 0, 5'h1F, 0, "R6 events disabled");
    op(1, 16'h0001, 0, 0, 0, 1, "R8 clear run while busy");
    op(0, 16'h0000, 0, 0, 0, 1, "R2 busy bit");
    op(1, 16'h0001, 0, 0, 0, 0, "R8 clear run idle");
    op(0, 16'h0000, 1, 5'h15, 0, 0, "R10 cfg write unlocked");
    op(0, 16'h0000, 0, 0, 5'h1F, 0, "R6 mixed enables");
    op(1, 16'h0F50, 0, 0, 5'h01, 0, "R7 event beats clear");
    op(1, 16'h0010, 0, 0, 5'h10, 0, "R7 rx unf event beats clear");
    op(1, 16'h0004, 0, 0, 5'h04, 0, "R6 abort event");
    op(1, 16'h0F50, 0, 0, 0, 0, "R5 bulk clear keeps master");
    op(1, 16'h0002, 1, 5'h0A, 0, 0, "R10 write same cycle as run set");
    op(0, 16'h0000, 0, 0, 5'h0A, 0, "R6 rx ovf tx unf enabled");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule